// File: doc/BRIEF.md
# Selectable Digital IQ Modulator

This block shifts a pair of interpolated baseband streams, I and Q, up by a tone locked to a fixed fraction of the sample rate. A 2-bit field picks the tone: none, fs/2, fs/4 or fs/8. The fs/2 and fs/4 carriers are sign changes and zeros. The fs/8 carrier needs one fixed coefficient, 0.7071 in Q15, and that is the only multiply in the block. Each product is rounded back to the sample width and saturated.

Two mixing styles are available. In real mixing, each channel is multiplied by the cosine carrier on its own, and no sample crosses from one channel to the other. In complex mixing, I and Q form one complex sample that is rotated. A sign input selects the rotation direction, so that either image can be rejected after an external quadrature modulator.

A 3-bit phase counter steps only on accepted samples. It restarts at phase 0 when the mode field changes. The output is registered one cycle after each valid input.

Top module: `iq_tone_mixer`

## Requirements
- R1: With `mode` = 2'b00 both outputs equal the inputs, in either mixing style.
- R2: With `mode` = 2'b01 the cosine carrier is +1 at even phases and −1 at odd phases, and the sine carrier is 0.
- R3: With `mode` = 2'b10 the cosine carrier steps 1, 0, −1, 0 and the sine carrier steps 0, 1, 0, −1 over phases 0 to 3, then repeats.
- R4: With `mode` = 2'b11 the cosine carrier at phases 0 to 7 is 1, c, 0, −c, −1, −c, 0, c, and the sine carrier is 0, c, 1, c, 0, −c, −1, −c, where c = 23170/32768. Each result is (sum of products in Q15 + 16384) shifted right arithmetically by 15.
- R5: With `real_mix` = 1, `out_i` = round(I·cos) and `out_q` = round(Q·cos). Neither output depends on the other channel's input.
- R6: With `real_mix` = 0 and `neg_rot` = 0, `out_i` = round(I·cos − Q·sin) and `out_q` = round(Q·cos + I·sin).
- R7: With `real_mix` = 0 and `neg_rot` = 1, `out_i` = round(I·cos + Q·sin) and `out_q` = round(Q·cos − I·sin).
- R8: The phase counter advances by one, modulo 8, only on a cycle with `in_valid` high. A cycle with `in_valid` low gives `out_valid` low on the next cycle and leaves `out_i` and `out_q` unchanged.
- R9: A sample taken in a cycle where `mode` differs from its value in the previous cycle uses phase 0. A mode change during idle cycles also returns the counter to 0.
- R10: While `rst_n` is low, `out_valid`, `out_i` and `out_q` are 0 and the phase returns to 0.
- R11: A sample accepted at a clock edge shows up on `out_valid`, `out_i` and `out_q` right after that edge, with a latency of one cycle.
- R12: Results above 32767 or below −32768 saturate to those limits, for the default width W = 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Carrier select: 00 none, 01 fs/2, 10 fs/4, 11 fs/8 |
| real_mix | input | 1 | 1: independent real mixing; 0: complex rotation |
| neg_rot | input | 1 | Rotation sign in complex mixing: 0 is e^{+jωt}, 1 is e^{−jωt} |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | W | Signed I sample |
| in_q | input | W | Signed Q sample |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | W | Mixed I sample |
| out_q | output | W | Mixed Q sample |

## Verification
Every result is due exactly one clock after the edge that accepted its sample: `out_valid`, `out_i` and `out_q` all come from one register stage. The bench drives each sample at a falling edge and lets one rising edge pass. It then checks all three outputs at the next falling edge, before it drives anything new. The bench keeps its own phase counter, which follows the same one-edge rule. It advances on each strobed sample and clears whenever the mode seen at an edge differs from the mode seen at the edge before. Idle cycles are checked at the same point for a low strobe and held data.

// File: rtl/iq_tone_mixer.sv
`timescale 1ns/1ps
module iq_tone_mixer #(
  parameter int W  = 16,
  parameter int CW = 16
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          mode,
  input  logic                real_mix,
  input  logic                neg_rot,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_i,
  input  logic signed [W-1:0] in_q,
  output logic                out_valid,
  output logic signed [W-1:0] out_i,
  output logic signed [W-1:0] out_q
);

  localparam int FRAC = CW - 1;
  localparam int KC   = $rtoi(0.7071067811865476 * (2.0 ** FRAC) + 0.5);
  localparam int PW   = W + CW + 1;
  localparam int SW   = PW + 1;
  localparam logic signed [SW-1:0] HI   = SW'((64'sd1 <<< (W-1)) - 64'sd1);
  localparam logic signed [SW-1:0] LO   = -HI - SW'(1);
  localparam logic signed [SW-1:0] HALF = SW'(64'sd1 <<< (FRAC-1));
  localparam logic signed [W-1:0]  SMIN = {1'b1, {(W-1){1'b0}}};

  typedef enum logic [2:0] {K_ZERO, K_P1, K_N1, K_PC, K_NC} coef_e;

  function automatic coef_e flip(coef_e k);
    case (k)
      K_P1:    return K_N1;
      K_N1:    return K_P1;
      K_PC:    return K_NC;
      K_NC:    return K_PC;
      default: return K_ZERO;
    endcase
  endfunction

  function automatic logic signed [PW-1:0] term(logic signed [W-1:0] x, coef_e k);
    logic signed [PW-1:0] xe, sh, mc;
    xe = PW'(x);
    sh = xe <<< FRAC;
    mc = xe * PW'(KC);
    case (k)
      K_P1:    return sh;
      K_N1:    return -sh;
      K_PC:    return mc;
      K_NC:    return -mc;
      default: return '0;
    endcase
  endfunction

  function automatic logic signed [W-1:0] rnd_sat(logic signed [SW-1:0] s);
    logic signed [SW-1:0] r;
    r = (s + HALF) >>> FRAC;
    if (r > HI) return W'(HI);
    if (r < LO) return W'(LO);
    return W'(r);
  endfunction

  logic [2:0] ph, ph_use;
  logic [1:0] mode_q;
  coef_e      kc, ks, ks_i, ks_q;
  logic signed [SW-1:0] sum_i, sum_q, x_i, x_q;

  assign ph_use = (mode != mode_q) ? 3'd0 : ph;

  always_comb begin
    kc = K_P1;
    ks = K_ZERO;
    unique case (mode)
      2'b01: kc = ph_use[0] ? K_N1 : K_P1;
      2'b10:
        case (ph_use[1:0])
          2'd0: kc = K_P1;
          2'd1: begin kc = K_ZERO; ks = K_P1; end
          2'd2: kc = K_N1;
          default: begin kc = K_ZERO; ks = K_N1; end
        endcase
      2'b11:
        case (ph_use)
          3'd0: kc = K_P1;
          3'd1: begin kc = K_PC;   ks = K_PC; end
          3'd2: begin kc = K_ZERO; ks = K_P1; end
          3'd3: begin kc = K_NC;   ks = K_PC; end
          3'd4: kc = K_N1;
          3'd5: begin kc = K_NC;   ks = K_NC; end
          3'd6: begin kc = K_ZERO; ks = K_N1; end
          default: begin kc = K_PC; ks = K_NC; end
        endcase
      default: ;
    endcase
  end

  assign ks_i  = neg_rot ? ks : flip(ks);
  assign ks_q  = neg_rot ? flip(ks) : ks;
  assign x_i   = real_mix ? SW'(0) : SW'(term(in_q, ks_i));
  assign x_q   = real_mix ? SW'(0) : SW'(term(in_i, ks_q));
  assign sum_i = SW'(term(in_i, kc)) + x_i;
  assign sum_q = SW'(term(in_q, kc)) + x_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= '0;
      mode_q    <= '0;
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      mode_q    <= mode;
      out_valid <= in_valid;
      if (in_valid) begin
        ph    <= ph_use + 3'd1;
        out_i <= rnd_sat(sum_i);
        out_q <= rnd_sat(sum_q);
      end else if (mode != mode_q) begin
        ph <= '0;
      end
    end
  end

  a_r11_strobe_next: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_i) && $stable(out_q)));

  a_r1_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b00) |=> (out_i == $past(in_i) && out_q == $past(in_q)));

  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && real_mix && mode == 2'b01 && mode != $past(mode) && in_i != SMIN)
      |=> (out_i == $past(in_i)));

  a_r3_quarter_null: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && real_mix && mode == 2'b10 && ph_use[0]) |=> (out_i == '0 && out_q == '0));

endmodule

// File: tb/sim_iq_tone_mixer.sv
`timescale 1ns/1ps
module sim_iq_tone_mixer;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic real_mix = 1'b1;
  logic neg_rot = 1'b0;
  logic in_valid = 1'b0;
  logic signed [15:0] in_i = '0;
  logic signed [15:0] in_q = '0;
  logic out_valid;
  logic signed [15:0] out_i, out_q;

  int n_chk = 0;
  int n_bad = 0;
  int bph = 0;
  int bprev = 0;
  bit done = 0;

  iq_tone_mixer u0 (.clk(clk), .rst_n(rst_n), .mode(mode), .real_mix(real_mix),
    .neg_rot(neg_rot), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q));

  always #2 clk = ~clk;

  localparam int NV = 28;
  localparam logic [35:0] VEC [NV] = '{
    {2'd0, 1'b1, 1'b0, 16'sd1000, -16'sd2000},
    {2'd0, 1'b1, 1'b0, 16'h8000, 16'h7FFF},
    {2'd0, 1'b0, 1'b0, 16'sd123, -16'sd456},
    {2'd1, 1'b1, 1'b0, 16'sd1000, -16'sd2000},
    {2'd1, 1'b1, 1'b0, 16'sd1000, -16'sd2000},
    {2'd1, 1'b1, 1'b0, -16'sd3000, 16'sd250},
    {2'd1, 1'b0, 1'b1, -16'sd3000, 16'sd250},
    {2'd2, 1'b1, 1'b0, 16'sd3000, -16'sd7000},
    {2'd2, 1'b1, 1'b0, 16'sd3000, -16'sd7000},
    {2'd2, 1'b1, 1'b0, 16'sd3000, -16'sd7000},
    {2'd2, 1'b1, 1'b0, 16'sd3000, -16'sd7000},
    {2'd2, 1'b0, 1'b0, 16'sd3000, -16'sd7000},
    {2'd2, 1'b0, 1'b0, 16'sd3000, -16'sd7000},
    {2'd2, 1'b0, 1'b0, 16'sd3000, -16'sd7000},
    {2'd2, 1'b0, 1'b0, 16'sd3000, -16'sd7000},
    {2'd2, 1'b0, 1'b1, 16'sd3000, -16'sd7000},
    {2'd2, 1'b0, 1'b1, 16'sd3000, -16'sd7000},
    {2'd3, 1'b1, 1'b0, 16'sd10000, 16'sd20000},
    {2'd3, 1'b1, 1'b0, 16'sd10000, -16'sd20000},
    {2'd3, 1'b1, 1'b0, -16'sd10000, 16'sd20000},
    {2'd3, 1'b0, 1'b0, -16'sd12345, 16'sd6789},
    {2'd3, 1'b0, 1'b0, -16'sd12345, 16'sd6789},
    {2'd3, 1'b0, 1'b0, -16'sd12345, 16'sd6789},
    {2'd3, 1'b0, 1'b0, -16'sd12345, 16'sd6789},
    {2'd3, 1'b0, 1'b1, -16'sd12345, 16'sd6789},
    {2'd3, 1'b0, 1'b1, -16'sd12345, 16'sd6789},
    {2'd3, 1'b0, 1'b1, -16'sd12345, 16'sd6789},
    {2'd3, 1'b0, 1'b1, -16'sd12345, 16'sd6789}
  };

  function automatic int carrier(input int m, input int p, input bit want_sin);
    int c;
    c = 23170;
    case (m)
      1: return want_sin ? 0 : ((p % 2) != 0 ? -32768 : 32768);
      2: case (p % 4)
           0: return want_sin ? 0 : 32768;
           1: return want_sin ? 32768 : 0;
           2: return want_sin ? 0 : -32768;
           default: return want_sin ? -32768 : 0;
         endcase
      3: case (p % 8)
           0: return want_sin ? 0 : 32768;
           1: return c;
           2: return want_sin ? 32768 : 0;
           3: return want_sin ? c : -c;
           4: return want_sin ? 0 : -32768;
           5: return -c;
           6: return want_sin ? -32768 : 0;
           default: return want_sin ? -c : c;
         endcase
      default: return want_sin ? 0 : 32768;
    endcase
  endfunction

  function automatic int rsat(input longint a);
    longint r;
    r = (a + 64'sd16384) >>> 15;
    if (r > 32767) return 32767;
    if (r < -32768) return -32768;
    return int'(r);
  endfunction

  function automatic string tag_of(input int m, input bit r, input bit n);
    if (m == 0) return "R1";
    if (!r) return n ? "R7" : "R6";
    if (m == 1) return "R2";
    if (m == 2) return "R3";
    return "R4";
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic send(input int m, input bit r, input bit n, input int i, input int q,
                      input string tag);
    int pu, ci, si, s, ei, eq;
    mode = 2'(m); real_mix = r; neg_rot = n;
    in_i = 16'(i); in_q = 16'(q); in_valid = 1'b1;
    pu = (m != bprev) ? 0 : bph;
    ci = carrier(m, pu, 1'b0);
    si = carrier(m, pu, 1'b1);
    s  = n ? -1 : 1;
    if (r) begin
      ei = rsat(longint'(i) * ci);
      eq = rsat(longint'(q) * ci);
    end else begin
      ei = rsat(longint'(i) * ci - longint'(s) * q * si);
      eq = rsat(longint'(q) * ci + longint'(s) * i * si);
    end
    @(posedge clk);
    bprev = m;
    bph = (pu + 1) % 8;
    @(negedge clk);
    chk("R11", "out_valid", int'(out_valid), 1);
    chk(tag, "out_i", int'(out_i), ei);
    chk(tag, "out_q", int'(out_q), eq);
  endtask

  task automatic idle(input int cycles, input int m);
    int hi, hq;
    for (int k = 0; k < cycles; k++) begin
      hi = int'(out_i); hq = int'(out_q);
      mode = 2'(m); in_valid = 1'b0;
      if (m != bprev) bph = 0;
      @(posedge clk);
      bprev = m;
      @(negedge clk);
      chk("R8", "idle out_valid", int'(out_valid), 0);
      chk("R8", "idle out_i held", int'(out_i), hi);
      chk("R8", "idle out_q held", int'(out_q), hq);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", "reset out_valid", int'(out_valid), 0);
    chk("R10", "reset out_i", int'(out_i), 0);
    chk("R10", "reset out_q", int'(out_q), 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      send(int'(VEC[v][35:34]), VEC[v][33], VEC[v][32],
           int'($signed(VEC[v][31:16])), int'($signed(VEC[v][15:0])),
           tag_of(int'(VEC[v][35:34]), VEC[v][33], VEC[v][32]));
    end

    // R8: idle gap keeps the phase; next fs/2 sample lands on phase 1
    send(1, 1'b1, 1'b0, 500, -700, "R9");
    idle(3, 1);
    send(1, 1'b1, 1'b0, 500, -700, "R8");
    chk("R8", "phase 1 after gap", int'(out_i), -500);

    // R9: mode change mid-stream restarts at phase 0
    send(2, 1'b1, 1'b0, 4321, -1234, "R9");
    chk("R9", "fs/4 phase 0 passes I", int'(out_i), 4321);
    // R9: mode change while idle also clears the phase
    send(2, 1'b1, 1'b0, 4321, -1234, "R3");
    idle(1, 3);
    idle(1, 2);
    send(2, 1'b1, 1'b0, 4321, -1234, "R9");
    chk("R9", "idle mode change clears phase", int'(out_q), -1234);

    // R12: saturation of -32768 * -1 and of a large complex sum
    send(1, 1'b1, 1'b0, 100, 100, "R2");
    send(1, 1'b1, 1'b0, -32768, 16, "R12");
    chk("R12", "fs/2 negate of min", int'(out_i), 32767);
    send(3, 1'b0, 1'b0, 1, 1, "R6");
    send(3, 1'b0, 1'b0, 32767, 32767, "R12");
    chk("R12", "complex fs/8 sum clipped", int'(out_q), 32767);

    // R5: real mix ignores the other channel (cos = 0 at fs/8 phase 2)
    send(0, 1'b1, 1'b0, 1, 1, "R1");
    send(3, 1'b1, 1'b0, 9000, -9000, "R5");
    send(3, 1'b1, 1'b0, 9000, 32767, "R5");
    chk("R5", "out_i free of Q", int'(out_i), 6364);
    send(3, 1'b1, 1'b0, 30000, -30000, "R5");
    chk("R5", "out_i zero at cos 0", int'(out_i), 0);
    chk("R5", "out_q zero at cos 0", int'(out_q), 0);

    idle(2, 3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule